// File: doc/BRIEF.md
# Paged Microcode Sequencer

This block drives the address of the microcode store in a CPU whose instruction set can be exchanged at run time, and it registers each microword that comes back. The address has three fields. A page register selects one of sixteen complete instruction sets, the opcode register selects the instruction, and a step counter selects the microinstruction within the fixed sixteen-entry slot that each opcode owns. An opcode whose function is built from microcode runs for more steps than it would with dedicated hardware. Because the slot length is fixed, the longer sequence has no effect on the address layout.

The registered microword goes to the datapath. Three of its bits are commands to this block. The fetch command starts the next instruction. The step-clear command restarts the current opcode's sequence. The page-write command stages a new instruction-set page. A staged page becomes active only when the next opcode is fetched, so an instruction never runs with a page that changes in its middle.

The store has one cycle of latency. As a result, the microword that was read in the same cycle as a fetch command still executes, in the manner of a delay slot. The microcode must account for it.

Top module: `useq_paged`

## Requirements
- R1: `rom_addr` is always `{page, opcode, step}`: the page in bits 15:12, the opcode in bits 11:4 and the step in bits 3:0.
- R2: When the executing microword has neither fetch nor step-clear set, the step goes up by one on the next clock, and it wraps from 15 to 0.
- R3: When bit 23 (fetch) of the executing microword is set, the next clock loads `opcode` from `data_bus` and sets `step` to 0.
- R4: When bit 21 (page write) is set without fetch, `data_bus[3:0]` is staged. `page` takes the staged value only at the next fetch, and at no other time.
- R5: `uword` holds `rom_data` as sampled at the previous clock edge. All commands act on `uword`.
- R6: When bit 22 (step clear) is set without fetch, the next clock sets `step` to 0 and keeps `opcode` unchanged.
- R7: While `rst_n` is low, `page`, the staged page, `opcode`, `step` and `uword` are all 0, so `rom_addr` is 0.
- R8: If fetch and page write are set in the same microword, the page write is dropped. The staged page keeps its previous value, and that value is the one the fetch activates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_bus | input | 8 | Opcode source for fetch; bits 3:0 give the page value for page write |
| rom_data | input | 24 | Microword read from the store at `rom_addr` |
| rom_addr | output | 16 | Microcode store address |
| uword | output | 24 | Registered microword driven to the datapath |
| page | output | 4 | Active instruction-set page |
| opcode | output | 8 | Current opcode |
| step | output | 4 | Step within the opcode's slot |

## Verification
The bench builds the block with its default widths: a 4-bit page, an 8-bit opcode, a 4-bit step and a 24-bit microword. With these widths, a pseudo-random data bus sweeps through every nonzero opcode under every page, and a computed store ends each opcode at a different step, including steps 0 and 15. Injected step-clear and fetch-with-page-write words, together with a stretch where all fetches are suppressed, bring the wrap, the restart and the dropped-write cases into reach. Every output is compared with an independent cycle model on every cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef struct packed {
        logic fetch;
        logic clr;
        logic pwr;
    } useq_cmd_t;

endpackage

// File: rtl/useq_cmd_dec.sv
module useq_cmd_dec
    import useq_pkg::*;
#(
    parameter int UW_W      = 24,
    parameter int FETCH_BIT = 23,
    parameter int CLR_BIT   = 22,
    parameter int PWR_BIT   = 21
) (
    input  logic [UW_W-1:0] uword_i,
    output useq_cmd_t       cmd_o
);
    always_comb begin
        cmd_o       = '0;
        cmd_o.fetch = uword_i[FETCH_BIT];
        cmd_o.clr   = uword_i[CLR_BIT];
        cmd_o.pwr   = uword_i[PWR_BIT] & ~uword_i[FETCH_BIT];
    end
endmodule

// File: rtl/useq_step_ctr.sv
module useq_step_ctr #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    output logic [STEP_W-1:0] step_o
);
    logic [STEP_W-1:0] step_d, step_q;

    always_comb begin
        if (restart_i) step_d = '0;
        else           step_d = step_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    assign step_o = step_q;
endmodule

// File: rtl/useq_page_reg.sv
module useq_page_reg #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_i,
    input  logic [PAGE_W-1:0] stage_val_i,
    input  logic              commit_i,
    output logic [PAGE_W-1:0] page_o
);
    typedef struct packed {
        logic [PAGE_W-1:0] staged;
        logic [PAGE_W-1:0] active;
    } page_st_t;

    page_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i)     st_d.active = st_q.staged;
        else if (stage_i) st_d.staged = stage_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page_o = st_q.active;
endmodule

// File: rtl/useq_paged.sv
module useq_paged
    import useq_pkg::*;
#(
    parameter int PAGE_W    = 4,
    parameter int OP_W      = 8,
    parameter int STEP_W    = 4,
    parameter int UW_W      = 24,
    parameter int FETCH_BIT = 23,
    parameter int CLR_BIT   = 22,
    parameter int PWR_BIT   = 21,
    localparam int ADDR_W   = PAGE_W + OP_W + STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   data_bus,
    input  logic [UW_W-1:0]   rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [UW_W-1:0]   uword,
    output logic [PAGE_W-1:0] page,
    output logic [OP_W-1:0]   opcode,
    output logic [STEP_W-1:0] step
);
    typedef struct packed {
        logic [OP_W-1:0] op;
        logic [UW_W-1:0] uw;
    } core_st_t;

    core_st_t  st_d, st_q;
    useq_cmd_t cmd;

    useq_cmd_dec #(
        .UW_W(UW_W), .FETCH_BIT(FETCH_BIT), .CLR_BIT(CLR_BIT), .PWR_BIT(PWR_BIT)
    ) u_dec (
        .uword_i(st_q.uw),
        .cmd_o  (cmd)
    );

    useq_step_ctr #(.STEP_W(STEP_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(cmd.fetch | cmd.clr),
        .step_o   (step)
    );

    useq_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_i    (cmd.pwr),
        .stage_val_i(data_bus[PAGE_W-1:0]),
        .commit_i   (cmd.fetch),
        .page_o     (page)
    );

    always_comb begin
        st_d    = st_q;
        st_d.uw = rom_data;
        if (cmd.fetch) st_d.op = data_bus;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign opcode   = st_q.op;
    assign uword    = st_q.uw;
    assign rom_addr = {page, st_q.op, step};
endmodule

// File: rtl/useq_paged_chk.sv
module useq_paged_chk #(
    parameter int PAGE_W    = 4,
    parameter int OP_W      = 8,
    parameter int STEP_W    = 4,
    parameter int UW_W      = 24,
    parameter int FETCH_BIT = 23,
    parameter int CLR_BIT   = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   data_bus,
    input logic [UW_W-1:0]   rom_data,
    input logic [UW_W-1:0]   uword,
    input logic [PAGE_W-1:0] page,
    input logic [OP_W-1:0]   opcode,
    input logic [STEP_W-1:0] step
);
    p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!uword[FETCH_BIT] && !uword[CLR_BIT]) |=> step == STEP_W'($past(step) + 1'b1));

    p_fetch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uword[FETCH_BIT] |=> (opcode == $past(data_bus)) && (step == '0));

    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !uword[FETCH_BIT] |=> $stable(page));

    p_uword_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> uword == $past(rom_data));

    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uword[CLR_BIT] && !uword[FETCH_BIT]) |=> (step == '0) && $stable(opcode));
endmodule

bind useq_paged useq_paged_chk #(
    .PAGE_W(PAGE_W), .OP_W(OP_W), .STEP_W(STEP_W), .UW_W(UW_W),
    .FETCH_BIT(FETCH_BIT), .CLR_BIT(CLR_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .data_bus(data_bus), .rom_data(rom_data),
    .uword(uword), .page(page), .opcode(opcode), .step(step)
);

// File: tb/tb_useq_paged.sv
module tb_useq_paged;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  data_bus = 8'h5b;
    logic [23:0] rom_data;
    logic [15:0] rom_addr;
    logic [23:0] uword;
    logic [3:0]  page;
    logic [7:0]  opcode;
    logic [3:0]  step;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic nofetch = 1'b0;
    logic inj_on  = 1'b0;
    logic [23:0] inj = '0;

    always #4 clk = ~clk;

    useq_paged dut (
        .clk(clk), .rst_n(rst_n), .data_bus(data_bus), .rom_data(rom_data),
        .rom_addr(rom_addr), .uword(uword), .page(page), .opcode(opcode), .step(step)
    );

    // computed store: ends each opcode at step (op ^ page) & 15
    function automatic logic [23:0] rom_fn(input logic [15:0] a, input logic nf);
        logic [23:0] w;
        logic [3:0]  pg, st;
        logic [7:0]  op;
        pg = a[15:12]; op = a[11:4]; st = a[3:0];
        w = {3'b000, op, pg, st, 5'(op[4:0] + {1'b0, st})};
        w[23] = (st == (op[3:0] ^ pg)) && !nf;
        w[21] = (st == 4'd1) && (op[2:0] == 3'b101);
        return w;
    endfunction

    assign rom_data = rom_fn(rom_addr, nofetch) | inj;

    // reference model
    logic [3:0]  m_page = '0, m_stage = '0, m_step = '0;
    logic [7:0]  m_op = '0;
    logic [23:0] m_uw = '0;
    logic        m_clr_hit = 1'b0, m_combo = 1'b0, m_r8_chk = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_page <= '0; m_stage <= '0; m_step <= '0; m_op <= '0; m_uw <= '0;
            m_clr_hit <= 1'b0; m_combo <= 1'b0; m_r8_chk <= 1'b0;
        end else begin
            m_uw <= rom_fn({m_page, m_op, m_step}, nofetch) | inj;
            m_clr_hit <= m_uw[22] && !m_uw[23];
            m_r8_chk  <= m_uw[23] && m_combo;
            if (m_uw[23]) begin
                m_op <= data_bus; m_step <= '0; m_page <= m_stage;
                m_combo <= m_uw[21];
            end else begin
                m_step <= m_uw[22] ? 4'd0 : m_step + 4'd1;
                if (m_uw[21]) m_stage <= data_bus[3:0];
            end
        end
    end

    // stimulus on the falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        data_bus <= {data_bus[6:0], data_bus[7] ^ data_bus[5] ^ data_bus[4] ^ data_bus[3]};
        if (inj_on && (cyc % 53 == 0))      inj <= 24'ha00000;
        else if (inj_on && (cyc % 37 == 0)) inj <= 24'h400000;
        else                                inj <= '0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("R1 rom_addr", 32'(rom_addr), 32'({m_page, m_op, m_step}));
        chk(nofetch ? "R2 step wrap" : "R2 step", 32'(step), 32'(m_step));
        chk("R3 opcode", 32'(opcode), 32'(m_op));
        chk(m_r8_chk ? "R8 page after dropped write" : "R4 page", 32'(page), 32'(m_page));
        chk("R5 uword", 32'(uword), 32'(m_uw));
        if (m_clr_hit) chk("R6 step clear", 32'(step), 32'd0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            compare_all();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R7 reset page", 32'(page), 32'd0);
        chk("R7 reset opcode", 32'(opcode), 32'd0);
        chk("R7 reset step", 32'(step), 32'd0);
        chk("R7 reset uword", 32'(uword), 32'd0);
        chk("R7 reset rom_addr", 32'(rom_addr), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        run(12000);
        inj_on = 1'b1;
        run(12000);
        inj_on = 1'b0;
        @(negedge clk); nofetch = 1'b1;
        run(40);
        nofetch = 1'b0;
        run(300);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule